// File: doc/BRIEF.md
# Triple-Read-Port Register File

This block is the general-purpose register store for a 32-bit pipelined processor. It holds 32 words of 32 bits. In every clock cycle it returns three words, one for the first source operand, one for the second source operand and one for the destination operand. In the same cycle it can accept one write from the writeback stage. The write port has its own address, data and write strobe, which are independent of the three read addresses.

Reads are synchronous. The decode stage presents the read addresses from its combinational next-state values, so the three words appear one cycle later, in step with the registered decode outputs that enter execute. The three read ports are made from three identical banks. Each bank has one write port and one read port, every bank receives the same write, and each bank serves one read port. When a read and a write hit the same address in the same cycle, the read returns the word being written. A global enable freezes the block: while it is low, nothing is written and all three read outputs keep their values.

The block has no reset, and register 0 is stored like any other register. Suppressing writes to register 0 is left to the decoder.

Top module: `rf3_regfile`

## Requirements
- R1: On every rising edge with `en` high, each read port `rd_data_x` takes the stored word at the address on `rd_addr_x` at that edge. The three addresses are independent of each other.
- R2: A write accepted at one edge is visible on all three read ports. Reading the written address on ports A, B and D afterwards returns the same word on each.
- R3: When `en` and `wr_en` are high and `wr_addr` equals a port's read address at the same edge, that port returns `wr_data` and not the older contents.
- R4: With `wr_en` low, no register changes, whatever is on `wr_addr` and `wr_data`.
- R5: With `en` low, no register is written even if `wr_en` is high, and all three read outputs keep their previous values whatever the read addresses are.
- R6: Address 0 is an ordinary storage location. A write to it is stored and read back like any other register.
- R7: The address is 5 bits wide and selects 32 distinct 32-bit registers. Writing a distinct word to every address and then reading each one back returns its own word.
- R8: A read of an address that is not being written in the same cycle returns the word stored before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| en | input | 1 | Global enable; low freezes writes and read outputs |
| rd_addr_a | input | 5 | Read address, operand A port (next-state decode value) |
| rd_addr_b | input | 5 | Read address, operand B port |
| rd_addr_d | input | 5 | Read address, destination port |
| wr_en | input | 1 | Write strobe from writeback |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_data_b | output | 32 | Registered read data, port B |
| rd_data_d | output | 32 | Registered read data, port D |

## Verification
The bench first fills all 32 locations, including address 0, with distinct words, so an aliased or dropped address shows up as the wrong word. It then issues independent random read triples with no writes, which separates a correct per-port address path from crossed ports. Writes with all three reads aimed at the written address tell a working same-cycle bypass apart from stale data, and they also show whether every bank got the write. Phases with the write strobe low, or with the enable low, drive changing addresses and data, then read back the targeted locations, which shows whether a write leaked through or an output moved.

// File: rtl/rf3_pkg.sv
package rf3_pkg;
    parameter int RF_ADDR_W = 5;
    parameter int RF_DATA_W = 32;
    parameter int RF_N_RD   = 3;
    localparam int RF_DEPTH = 1 << RF_ADDR_W;
endpackage

// File: rtl/rf3_wr_gate.sv
module rf3_wr_gate (
    input  logic en,
    input  logic wr_en,
    output logic wr_fire
);
    // Single qualified write strobe shared by all banks.
    always_comb begin
        wr_fire = en & wr_en;
    end
endmodule

// File: rtl/rf3_bank.sv
module rf3_bank #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } bank_st_t;

    logic [DW-1:0] mem_q [DEPTH];
    bank_st_t      st_d;
    bank_st_t      st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (wr_fire && (wr_addr == rd_addr)) begin
                st_d.rdata = wr_data;
            end else begin
                st_d.rdata = mem_q[rd_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (wr_fire) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = st_q.rdata;

    // Assertion qualifier: live after the first edge (no reset in this block).
    logic chk_live_q = 1'b0;
    always_ff @(posedge clk) begin
        chk_live_q <= 1'b1;
    end

    // R3: same-cycle write and read of one address returns the new word.
    a_r3_raw_bypass: assert property (@(posedge clk) disable iff (!chk_live_q)
        (en && wr_fire && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));

    // R5: enable low holds the read output.
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!chk_live_q)
        !en |=> $stable(rd_data));

    // R5: a write strobe never fires while the block is frozen.
    a_r5_no_write_when_off: assert property (@(posedge clk) disable iff (!chk_live_q)
        !en |-> !wr_fire);
endmodule

// File: rtl/rf3_regfile.sv
module rf3_regfile
    import rf3_pkg::*;
#(
    parameter int AW   = RF_ADDR_W,
    parameter int DW   = RF_DATA_W,
    parameter int N_RD = RF_N_RD
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    input  logic [AW-1:0] rd_addr_d,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b,
    output logic [DW-1:0] rd_data_d
);
    logic          wr_fire;
    logic [AW-1:0] rd_addr_v [N_RD];
    logic [DW-1:0] rd_data_v [N_RD];

    rf3_wr_gate i_wr_gate (
        .en      (en),
        .wr_en   (wr_en),
        .wr_fire (wr_fire)
    );

    always_comb begin
        for (int p = 0; p < N_RD; p++) begin
            rd_addr_v[p] = '0;
        end
        rd_addr_v[0] = rd_addr_a;
        rd_addr_v[1] = rd_addr_b;
        rd_addr_v[N_RD-1] = rd_addr_d;
    end

    // One replicated bank per read port; every bank sees the same write.
    for (genvar g = 0; g < N_RD; g++) begin : g_bank
        rf3_bank #(.AW(AW), .DW(DW)) i_bank (
            .clk     (clk),
            .en      (en),
            .wr_fire (wr_fire),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (rd_addr_v[g]),
            .rd_data (rd_data_v[g])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];
    assign rd_data_d = rd_data_v[N_RD-1];

    logic chk_live_q = 1'b0;
    always_ff @(posedge clk) begin
        chk_live_q <= 1'b1;
    end

    // R2: a bypassed write reaches ports A and D alike.
    a_r2_bypass_a_d_agree: assert property (@(posedge clk) disable iff (!chk_live_q)
        (en && wr_en && (wr_addr == rd_addr_a) && (wr_addr == rd_addr_d))
        |=> (rd_data_a == rd_data_d));

    // R2: a bypassed write reaches ports A and B alike.
    a_r2_bypass_a_b_agree: assert property (@(posedge clk) disable iff (!chk_live_q)
        (en && wr_en && (wr_addr == rd_addr_a) && (wr_addr == rd_addr_b))
        |=> (rd_data_a == rd_data_b));

    // R5: frozen block keeps all three outputs.
    a_r5_all_ports_hold: assert property (@(posedge clk) disable iff (!chk_live_q)
        !en |=> ($stable(rd_data_a) && $stable(rd_data_b) && $stable(rd_data_d)));
endmodule

// File: tb/test_rf3_regfile.sv
`timescale 1ns/1ps
module test_rf3_regfile;
    logic        clk = 1'b0;
    logic        en = 1'b0;
    logic [4:0]  ra [3];
    logic        we = 1'b0;
    logic [4:0]  wa = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd [3];

    always #2.5 clk = ~clk;

    rf3_regfile i_rf3_regfile (
        .clk(clk), .en(en),
        .rd_addr_a(ra[0]), .rd_addr_b(ra[1]), .rd_addr_d(ra[2]),
        .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_data_a(rd[0]), .rd_data_b(rd[1]), .rd_data_d(rd[2])
    );

    // Behavioural reference
    logic [31:0] model [32];
    bit          known [32];
    logic [31:0] exp_v [3];
    bit          exp_k [3];
    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    initial begin
        for (int i = 0; i < 32; i++) known[i] = 0;
        for (int p = 0; p < 3; p++) begin exp_k[p] = 0; ra[p] = '0; end
    end

    always @(posedge clk) begin
        if (en) begin
            for (int p = 0; p < 3; p++) begin
                if (we && wa == ra[p]) begin
                    exp_v[p] = wd; exp_k[p] = 1;
                end else begin
                    exp_v[p] = model[ra[p]]; exp_k[p] = known[ra[p]];
                end
            end
            if (we) begin model[wa] = wd; known[wa] = 1; end
        end
    end

    task automatic check_all();
        for (int p = 0; p < 3; p++) begin
            if (exp_k[p]) begin
                total++;
                if (rd[p] !== exp_v[p]) begin
                    bad++;
                    $display("FAIL %s port %0d got %h exp %h", cur_req, p, rd[p], exp_v[p]);
                end
            end
        end
    endtask

    task automatic step(input bit e, input bit w, input logic [4:0] a,
                        input logic [31:0] d, input logic [4:0] x0,
                        input logic [4:0] x1, input logic [4:0] x2);
        en = e; we = w; wa = a; wd = d;
        ra[0] = x0; ra[1] = x1; ra[2] = x2;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 and R6: fill every entry, address 0 included, with distinct words.
        cur_req = "R7";
        for (int i = 0; i < 32; i++)
            step(1, 1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'(i), 5'((i+31)%32), 5'(i));
        cur_req = "R6";
        step(1, 0, 0, 0, 5'd0, 5'd0, 5'd0);
        step(1, 1, 5'd0, 32'hDEAD0000, 5'd1, 5'd2, 5'd3);
        step(1, 0, 0, 0, 5'd0, 5'd0, 5'd0);
        // R1 and R8: independent random reads, no writes.
        cur_req = "R1";
        for (int i = 0; i < 40; i++)
            step(1, 0, 5'($urandom), $urandom, 5'($urandom), 5'($urandom), 5'($urandom));
        cur_req = "R8";
        step(1, 1, 5'd7, 32'h77770000, 5'd8, 5'd9, 5'd7);
        step(1, 0, 0, 0, 5'd7, 5'd8, 5'd7);
        // R3 and R2: write with all ports aimed at the written address.
        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            logic [4:0] a;
            a = 5'($urandom);
            step(1, 1, a, $urandom, a, a, a);
        end
        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            logic [4:0] a;
            a = 5'($urandom);
            step(1, 1, a, $urandom, 5'(a+1), 5'(a+2), 5'(a+3));
            step(1, 0, 0, 0, a, a, a);
        end
        // R4: write strobe low, busy address and data.
        cur_req = "R4";
        for (int i = 0; i < 20; i++)
            step(1, 0, 5'(i), 32'hFFFF0000 | 32'(i), 5'($urandom), 5'($urandom), 5'($urandom));
        for (int i = 0; i < 20; i++)
            step(1, 0, 0, 0, 5'(i), 5'(i), 5'(i));
        // R5: frozen block, write strobe high, addresses moving.
        cur_req = "R5";
        step(1, 0, 0, 0, 5'd4, 5'd5, 5'd6);
        for (int i = 0; i < 12; i++)
            step(0, 1, 5'(i), 32'hBAD00000 | 32'(i), 5'(i), 5'(i+3), 5'(i+5));
        for (int i = 0; i < 12; i++)
            step(1, 0, 0, 0, 5'(i), 5'(i), 5'(i));
        // Mixed traffic.
        cur_req = "R1";
        for (int i = 0; i < 200; i++)
            step(($urandom % 5) != 0, $urandom % 2, 5'($urandom), $urandom,
                 5'($urandom), 5'($urandom), 5'($urandom));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog run did not finish got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule